// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with its own programmable baud-rate generator. The transmit and receive halves share nothing but that generator, so a character can be sent while another is being received. The generator also works as a general-purpose timer that emits a periodic tick. Software reaches the port through four word-wide registers selected by a two-bit register select: received/transmit data, control, status and divisor.

Several nodes can share one receive line in multidrop mode. A node that does not want the traffic now on the line sets its sleep bit. While asleep, completed frames are thrown away and no receive interrupt is raised. The receiver wakes up in one of two ways. In idle mode it wakes once the line has stayed quiet for a whole frame time. In address mode it wakes when a frame arrives with its ninth (address) bit set, and that frame is kept. The receiver oversamples the line at sixteen ticks per bit and takes a two-of-three majority vote near the middle of each bit.

Top module: `mdsp_port`

## Requirements
- R1: After reset, txd is high, irq_rx, irq_tx and tmr_tick are low, and the control (sel 1), status (sel 2), divisor (sel 3) and data (sel 0) registers read 0, 0x01, 0 and 0.
- R2: The generator ticks once every DIV+1 clocks, where DIV is the divisor register. Every serial bit lasts 16 ticks, which is 16*(DIV+1) clocks.
- R3: A write to data (sel 0) fills a one-entry holding register. Status bit 0 (tx-empty) goes low, and any write made while it is low is dropped. The character is sent only while control bit 0 (tx enable) is 1. The frame is a 0 start bit, eight data bits LSB first, then data bit 8 of the write as a ninth bit when control bit 2 (nine-bit mode) is 1, then a 1 stop bit.
- R4: When control bit 1 (rx enable) is 1, each received frame appears at data bits [8:0], with bit 8 holding the ninth bit in nine-bit mode and 0 otherwise. It also sets status bit 1 (rx-full). A read of data clears rx-full. Frames that arrive while rx enable is 0 are not received.
- R5: Each bit is the majority of three samples near mid-bit. A one-clock glitch inside a bit leaves the value unchanged. A low pulse on an idle line that is shorter than half a bit is not taken as a start bit.
- R6: A frame whose stop bit samples as 0 is still delivered and sets status bit 3 (framing error). That flag follows the most recently delivered frame.
- R7: A frame that completes while rx-full is set is dropped and sets status bit 2 (overrun), and the earlier data stays readable. A data read clears overrun.
- R8: While control bit 3 (sleep) is 1, completed frames do not set rx-full or irq_rx.
- R9: With control bit 4 (wake mode) at 0, sleep clears itself once the line has been high with the receiver idle for 160 consecutive ticks (176 in nine-bit mode). Frames after that are received.
- R10: With wake mode at 1 in nine-bit mode, a frame whose ninth bit is 0 leaves the node asleep. A frame whose ninth bit is 1 clears sleep and is delivered.
- R11: While control bit 5 (timer enable) is 1, tmr_tick pulses for one clock every DIV+1 clocks. While it is 0, tmr_tick stays low.
- R12: irq_rx equals rx-full AND rx enable. irq_tx equals tx-empty AND tx enable.
- R13: A transmission and a reception can run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Register select: 0 data, 1 control, 2 status, 3 divisor |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of data clears rx-full and overrun) |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data for the selected register |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_tx | output | 1 | Transmit-empty interrupt |
| tmr_tick | output | 1 | Periodic timer pulse |

## Verification
The checker assumes that rx-full, overrun and sleep can change only through a register access or a completed frame. It also assumes that the bus strobes are single-cycle pulses whose select is stable in the cycle they are sampled. The bench drives every register access through tasks that assert one strobe for one clock. It drives the serial line only on falling clock edges, with whole bit periods derived from the divisor it has programmed. Glitches and runt start pulses are introduced on purpose, each at a known offset inside a bit. Sleep tests keep the quiet gap before a frame much shorter than the 160-tick wake window, so idle wake-up cannot occur early.

// File: rtl/mdsp_pkg.sv
package mdsp_pkg;

    localparam int OSR        = 16;
    localparam int PH_W       = $clog2(OSR);
    localparam int CHAR_W     = 8;
    localparam int WORD_W     = CHAR_W + 1;
    localparam int BITS_PLAIN = CHAR_W + 2;
    localparam int BITS_ADDR  = CHAR_W + 3;
    localparam int IDX_W      = $clog2(BITS_ADDR + 1);
    localparam int IDLE_W     = $clog2(OSR * BITS_ADDR + 1);

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DIV  = 2'd3
    } sel_e;

    // control word, LSB is tx enable
    typedef struct packed {
        logic tmr_en;
        logic wake_addr;
        logic sleep;
        logic nine;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic ferr;
        logic ovr;
        logic rx_full;
        logic tx_empty;
    } stat_t;

    typedef struct packed {
        logic              ferr;
        logic [WORD_W-1:0] word;
    } rx_frame_t;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    function automatic logic [IDX_W-1:0] frame_bits(input logic nine);
        return nine ? IDX_W'(BITS_ADDR) : IDX_W'(BITS_PLAIN);
    endfunction

    function automatic logic [IDLE_W-1:0] quiet_limit(input logic nine);
        return nine ? IDLE_W'(OSR * BITS_ADDR - 1) : IDLE_W'(OSR * BITS_PLAIN - 1);
    endfunction

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mdsp_baud.sv
module mdsp_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // down-counter, reloads on zero: period is div+1 clocks
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == '0)
            cnt <= div;
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/mdsp_tx.sv
module mdsp_tx
    import mdsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              nine,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic              txd,
    output logic              empty
);

    logic [WORD_W-1:0]    hold;
    logic                 hold_full;
    logic                 busy;
    logic [BITS_ADDR-1:0] shreg;
    logic [PH_W-1:0]      phase;
    logic [IDX_W-1:0]     left;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold      <= '0;
            hold_full <= 1'b0;
            busy      <= 1'b0;
            shreg     <= '1;
            phase     <= '0;
            left      <= '0;
        end else begin
            if (wr && !hold_full) begin
                hold      <= wdata;
                hold_full <= 1'b1;
            end
            if (!busy) begin
                if (hold_full && en) begin
                    busy      <= 1'b1;
                    hold_full <= 1'b0;
                    phase     <= '0;
                    left      <= frame_bits(nine);
                    shreg     <= {1'b1, (nine ? hold[CHAR_W] : 1'b1),
                                  hold[CHAR_W-1:0], 1'b0};
                end
            end else if (tick) begin
                phase <= phase + 1'b1;
                if (phase == PH_W'(OSR - 1)) begin
                    shreg <= {1'b1, shreg[BITS_ADDR-1:1]};
                    left  <= left - 1'b1;
                    if (left == IDX_W'(1))
                        busy <= 1'b0;
                end
            end
        end
    end

    assign txd   = busy ? shreg[0] : 1'b1;
    assign empty = !hold_full;

endmodule

// File: rtl/mdsp_rx.sv
module mdsp_rx
    import mdsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      en,
    input  logic      nine,
    input  logic      rxd,
    output rx_frame_t frame,
    output logic      frame_vld,
    output logic      quiet
);

    logic              s1, s2;
    rx_state_e         state;
    logic [PH_W-1:0]   phase;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        samp;
    logic [WORD_W-1:0] sh;
    logic              vote;
    logic [IDX_W-1:0]  stop_idx;

    assign vote     = majority3(samp[0], samp[1], s2);
    assign stop_idx = frame_bits(nine) - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= 1'b1;
            s2        <= 1'b1;
            state     <= RX_IDLE;
            phase     <= '0;
            idx       <= '0;
            samp      <= '0;
            sh        <= '0;
            frame     <= '0;
            frame_vld <= 1'b0;
        end else begin
            s1        <= rxd;
            s2        <= s1;
            frame_vld <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
            end else if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!s2) begin
                            state <= RX_BUSY;
                            phase <= '0;
                            idx   <= '0;
                        end
                    end
                    RX_BUSY: begin
                        phase <= phase + 1'b1;
                        if (phase == PH_W'(OSR/2 - 1))
                            samp[0] <= s2;
                        if (phase == PH_W'(OSR/2))
                            samp[1] <= s2;
                        if (phase == PH_W'(OSR/2 + 1)) begin
                            if (idx == '0) begin
                                if (vote)
                                    state <= RX_IDLE;
                            end else if (idx == stop_idx) begin
                                frame_vld  <= 1'b1;
                                frame.ferr <= !vote;
                                frame.word <= nine ? sh : {1'b0, sh[WORD_W-1:1]};
                                state      <= RX_IDLE;
                            end else begin
                                sh <= {vote, sh[WORD_W-1:1]};
                            end
                        end
                        if (phase == PH_W'(OSR - 1))
                            idx <= idx + 1'b1;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign quiet = (state == RX_IDLE) && s2;

endmodule

// File: rtl/mdsp_wake.sv
module mdsp_wake
    import mdsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic asleep,
    input  logic by_addr,
    input  logic nine,
    input  logic quiet,
    output logic wake
);

    logic [IDLE_W-1:0] cnt;
    logic [IDLE_W-1:0] limit;

    assign limit = quiet_limit(nine);

    // counts consecutive quiet ticks while asleep in idle-wake mode
    always_ff @(posedge clk) begin
        if (rst || !asleep || by_addr || !quiet)
            cnt <= '0;
        else if (tick && cnt != limit)
            cnt <= cnt + 1'b1;
    end

    assign wake = asleep && !by_addr && quiet && tick && (cnt == limit);

endmodule

// File: rtl/mdsp_port.sv
module mdsp_port
    import mdsp_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             rxd,
    output logic             txd,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             tmr_tick
);

    localparam int DIV_W = BUS_W;

    sel_e             rsel;
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    rx_frame_t        held;
    rx_frame_t        frame;
    logic             rx_full, ovr, tx_empty;
    logic             tick, frame_vld, quiet, idle_wake;
    logic             data_wr, data_rd, ctrl_wr, div_wr;
    logic             addr_hit, accept;
    stat_t            stat;

    assign rsel    = sel_e'(sel);
    assign data_wr = wr_en && rsel == SEL_DATA;
    assign data_rd = rd_en && rsel == SEL_DATA;
    assign ctrl_wr = wr_en && rsel == SEL_CTRL;
    assign div_wr  = wr_en && rsel == SEL_DIV;

    mdsp_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .div  (div),
        .tick (tick)
    );

    mdsp_tx u_tx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .en    (ctrl.tx_en),
        .nine  (ctrl.nine),
        .wr    (data_wr),
        .wdata (wdata[WORD_W-1:0]),
        .txd   (txd),
        .empty (tx_empty)
    );

    mdsp_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .en        (ctrl.rx_en),
        .nine      (ctrl.nine),
        .rxd       (rxd),
        .frame     (frame),
        .frame_vld (frame_vld),
        .quiet     (quiet)
    );

    mdsp_wake u_wake (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .asleep  (ctrl.sleep),
        .by_addr (ctrl.wake_addr),
        .nine    (ctrl.nine),
        .quiet   (quiet),
        .wake    (idle_wake)
    );

    assign addr_hit = ctrl.wake_addr && ctrl.nine && frame.word[CHAR_W];
    assign accept   = frame_vld && (!ctrl.sleep || addr_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            div     <= '0;
            held    <= '0;
            rx_full <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            else if (idle_wake || (frame_vld && ctrl.sleep && addr_hit))
                ctrl.sleep <= 1'b0;
            if (div_wr)
                div <= wdata;
            if (data_rd) begin
                rx_full <= 1'b0;
                ovr     <= 1'b0;
            end
            if (accept) begin
                if (rx_full && !data_rd) begin
                    ovr <= 1'b1;
                end else begin
                    held    <= frame;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    assign stat = '{ferr: held.ferr, ovr: ovr, rx_full: rx_full, tx_empty: tx_empty};

    always_comb begin
        rdata = '0;
        case (rsel)
            SEL_DATA: rdata[WORD_W-1:0] = held.word;
            SEL_CTRL: rdata[CTRL_W-1:0] = ctrl;
            SEL_STAT: rdata[$bits(stat_t)-1:0] = stat;
            SEL_DIV:  rdata = div;
            default:  rdata = '0;
        endcase
    end

    assign irq_rx   = rx_full && ctrl.rx_en;
    assign irq_tx   = tx_empty && ctrl.tx_en;
    assign tmr_tick = tick && ctrl.tmr_en;

endmodule

// File: rtl/mdsp_port_chk.sv
module mdsp_port_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic       rx_full,
    input logic       ovr,
    input logic       tx_empty,
    input logic       sleep,
    input logic       wake_addr
);

    // R4
    rxfull_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full) |-> $past(rd_en && sel == 2'd0));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(rx_full) && rx_full);

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr) |-> $past(rd_en && sel == 2'd0));

    // R8
    asleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_full) && $past(sleep)) |-> $past(wake_addr));

    // R3
    txempty_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_empty) |-> $past(wr_en && sel == 2'd0));

endmodule

bind mdsp_port mdsp_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rx_full   (rx_full),
    .ovr       (ovr),
    .tx_empty  (tx_empty),
    .sleep     (ctrl.sleep),
    .wake_addr (ctrl.wake_addr)
);

// File: tb/mdsp_port_bench.sv
`timescale 1ns/1ps
module mdsp_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        rxd = 1'b1;
    logic        txd, irq_rx, irq_tx, tmr_tick;

    int n_vec = 0;
    int n_bad = 0;
    int bp    = 16;

    always #4 clk = ~clk;

    mdsp_port u_mdsp_port (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .tmr_tick(tmr_tick)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        sel = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [15:0] e);
        logic [15:0] v;
        rd_reg(a, v);
        check(tag, {16'd0, v}, {16'd0, e});
    endtask

    // drive one frame on rxd; glitch_bit >= 0 inverts one clock mid-bit
    task automatic send_frame(input logic [7:0] d, input bit nine, input bit ab,
                              input bit stopv, input int glitch_bit);
        logic [10:0] seq;
        int n;
        n   = nine ? 11 : 10;
        seq = nine ? {stopv, ab, d, 1'b0} : {1'b1, stopv, d, 1'b0};
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < bp; k++) begin
                if (i == glitch_bit && k == bp/2)
                    rxd = ~seq[i];
                else
                    rxd = seq[i];
                @(negedge clk);
            end
        end
        rxd = 1'b1;
    endtask

    task automatic recv_tx(input bit nine, output logic [10:0] got);
        int t;
        int n;
        t   = 0;
        n   = nine ? 11 : 10;
        got = '1;
        while (txd !== 1'b0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (bp/2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            repeat (bp) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 txd", {31'd0, txd}, 32'd1);
        check("R1 irqs", {29'd0, irq_rx, irq_tx, tmr_tick}, 32'd0);
        expect_reg("R1 ctrl", 2'd1, 16'h0000);
        expect_reg("R1 stat", 2'd2, 16'h0001);
        expect_reg("R1 div", 2'd3, 16'h0000);
        expect_reg("R1 data", 2'd0, 16'h0000);
    endtask

    task automatic t_tx_plain();
        logic [10:0] got;
        wr_reg(2'd3, 16'd1);
        bp = 32;
        wr_reg(2'd0, 16'h0055);
        wr_reg(2'd0, 16'h00AA);
        expect_reg("R3 tx-empty low while held", 2'd2, 16'h0000);
        repeat (100) @(negedge clk);
        check("R3 idle while tx disabled", {31'd0, txd}, 32'd1);
        wr_reg(2'd1, 16'h0001);
        recv_tx(1'b0, got);
        check("R2 R3 plain frame at DIV=1", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'h55, 1'b0});
        expect_reg("R3 tx-empty after send", 2'd2, 16'h0001);
        check("R12 irq_tx", {31'd0, irq_tx}, 32'd1);
    endtask

    task automatic t_tx_nine();
        logic [10:0] got;
        wr_reg(2'd3, 16'd0);
        bp = 16;
        wr_reg(2'd1, 16'h0005);
        wr_reg(2'd0, 16'h01A3);
        recv_tx(1'b1, got);
        check("R3 nine-bit frame", {21'd0, got}, {21'd0, 1'b1, 1'b1, 8'hA3, 1'b0});
    endtask

    task automatic t_rx_basic();
        wr_reg(2'd1, 16'h0002);
        send_frame(8'hC5, 0, 0, 1, -1);
        expect_reg("R4 rx-full set", 2'd2, 16'h0003);
        check("R12 irq_rx", {31'd0, irq_rx}, 32'd1);
        expect_reg("R4 data", 2'd0, 16'h00C5);
        expect_reg("R4 cleared by read", 2'd2, 16'h0001);
        wr_reg(2'd1, 16'h0000);
        send_frame(8'h33, 0, 0, 1, -1);
        expect_reg("R4 rx disabled", 2'd2, 16'h0001);
    endtask

    task automatic t_majority();
        wr_reg(2'd1, 16'h0002);
        send_frame(8'h5A, 0, 0, 1, 4);
        expect_reg("R5 glitch rejected", 2'd0, 16'h005A);
        @(negedge clk);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        expect_reg("R5 runt start ignored", 2'd2, 16'h0001);
        send_frame(8'h81, 0, 0, 1, -1);
        expect_reg("R5 frame after runt", 2'd0, 16'h0081);
    endtask

    task automatic t_ferr();
        send_frame(8'h3C, 0, 0, 0, -1);
        repeat (40) @(negedge clk);
        expect_reg("R6 framing error", 2'd2, 16'h000B);
        expect_reg("R6 data kept", 2'd0, 16'h003C);
        send_frame(8'h11, 0, 0, 1, -1);
        expect_reg("R6 flag follows frame", 2'd2, 16'h0003);
        expect_reg("R6 data", 2'd0, 16'h0011);
    endtask

    task automatic t_overrun();
        send_frame(8'h21, 0, 0, 1, -1);
        send_frame(8'h42, 0, 0, 1, -1);
        expect_reg("R7 overrun", 2'd2, 16'h0007);
        expect_reg("R7 first data kept", 2'd0, 16'h0021);
        expect_reg("R7 cleared", 2'd2, 16'h0001);
    endtask

    task automatic t_sleep_idle();
        wr_reg(2'd1, 16'h000A);
        send_frame(8'h77, 0, 0, 1, -1);
        check("R8 no irq asleep", {31'd0, irq_rx}, 32'd0);
        expect_reg("R8 no rx-full asleep", 2'd2, 16'h0001);
        expect_reg("R9 still asleep", 2'd1, 16'h000A);
        repeat (170) @(negedge clk);
        expect_reg("R9 woke on idle", 2'd1, 16'h0002);
        send_frame(8'h66, 0, 0, 1, -1);
        expect_reg("R9 frame after wake", 2'd0, 16'h0066);
    endtask

    task automatic t_addr_wake();
        wr_reg(2'd1, 16'h001E);
        send_frame(8'h12, 1, 0, 1, -1);
        expect_reg("R10 data frame dropped", 2'd2, 16'h0001);
        expect_reg("R10 still asleep", 2'd1, 16'h001E);
        send_frame(8'h34, 1, 1, 1, -1);
        expect_reg("R10 address frame kept", 2'd0, 16'h0134);
        expect_reg("R10 sleep cleared", 2'd1, 16'h0016);
    endtask

    task automatic t_timer();
        int cnt;
        wr_reg(2'd1, 16'h0020);
        wr_reg(2'd3, 16'd3);
        repeat (8) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (tmr_tick) cnt++;
            @(negedge clk);
        end
        check("R11 timer pulses", cnt, 32'd10);
        wr_reg(2'd1, 16'h0000);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (tmr_tick) cnt++;
            @(negedge clk);
        end
        check("R11 timer off", cnt, 32'd0);
        wr_reg(2'd3, 16'd0);
        repeat (8) @(negedge clk);
        bp = 16;
    endtask

    task automatic t_duplex();
        logic [10:0] got;
        wr_reg(2'd1, 16'h0003);
        wr_reg(2'd0, 16'h004B);
        fork
            send_frame(8'h9E, 0, 0, 1, -1);
            recv_tx(1'b0, got);
        join
        check("R13 tx during rx", {22'd0, got[9:0]}, {22'd0, 1'b1, 8'h4B, 1'b0});
        expect_reg("R13 rx during tx", 2'd0, 16'h009E);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_plain();
        t_tx_nine();
        t_rx_basic();
        t_majority();
        t_ferr();
        t_overrun();
        t_sleep_idle();
        t_addr_wake();
        t_timer();
        t_duplex();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        report();
    end

endmodule